// File: doc/BRIEF.md
# Gated Conversion Step Clock Selector

This block supplies the step enable that advances a successive-approximation converter core, one enable per bit decision. It has two sources. A divider of the system clock runs only while a conversion is in progress. An external clock pin is brought into the system clock domain, and each of its rising edges becomes a single-cycle enable. The source is chosen by a select input. That select is captured once, on the cycle a conversion is accepted, so changing it mid-conversion cannot corrupt the step stream.

A step counter is cleared at each accepted start. It closes the gate once the configured number of steps (sixteen by default) has gone through, so further external edges never reach the core. Each step that passes the gate is mirrored on a registered clock output. The mirror stays high for a fixed number of system cycles and only while chip-select and read are both held low. Between conversions the mirror output is held low, which lets it serve as a master clock for a serial port.

The design is fully synchronous. Every gated clock is expressed as a one-cycle enable on the system clock.

Top module: `convclk_selector`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy`, `step_en`, `eoc` and `clk_mirror` are all 0.
- R2: With `src_sel` = 0 at the start, `step_en` is high for one cycle every INT_DIV system cycles. The first pulse arrives INT_DIV cycles after the edge that accepted `conv_start`.
- R3: With `src_sel` = 1 at the start, every rising edge of `ext_clk_in` yields exactly one `step_en` cycle, 2 cycles after the edge is first sampled (two-flop synchronizer). Edges that arrive while idle yield nothing.
- R4: Each conversion delivers exactly STEPS `step_en` pulses. `busy` then falls, and any further external edges are ignored.
- R5: `eoc` is a one-cycle pulse in the cycle right after the final step. `busy` is low in that same cycle.
- R6: A `conv_start` pulse that arrives while `busy` is high has no effect: the step count continues and is not restarted.
- R7: `src_sel` is sampled only when a start is accepted. Changing it during a conversion does not change the step source.
- R8: After each step edge at which `cs_n` = 0 and `rd_n` = 0, `clk_mirror` is high for the next MIRROR_HI cycles, as long as both stay low.
- R9: `clk_mirror` is low in any cycle that follows an edge where `cs_n` or `rd_n` was 1, and it stays low between conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Conversion request, accepted only while idle |
| src_sel | input | 1 | Step source: 0 internal divider, 1 external pin |
| ext_clk_in | input | 1 | Asynchronous external conversion clock |
| cs_n | input | 1 | Active-low select, gates the mirror output |
| rd_n | input | 1 | Active-low read, gates the mirror output |
| busy | output | 1 | Conversion in progress |
| step_en | output | 1 | One-cycle enable per converter step |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| clk_mirror | output | 1 | Registered copy of the gated steps |

## Verification
The properties assume that `conv_start`, `src_sel`, `cs_n` and `rd_n` are synchronous to `clk`. They also assume that external steps are spaced more than MIRROR_HI cycles apart, so mirrored pulses never merge. The stimulus drives every input on the falling clock edge. It toggles `ext_clk_in` with a half period of five system cycles, which is well above the mirror hold time. A behavioural reference model follows the divider, the synchronizer delay and the gating on every cycle. It also covers start pulses during a busy conversion, select flips mid-conversion, surplus external edges, and edges that arrive while idle.

// File: rtl/convclk_pkg.sv
package convclk_pkg;
   typedef enum logic {
      SRC_INTERNAL = 1'b0,
      SRC_EXTERNAL = 1'b1
   } step_src_e;

   function automatic int unsigned cnt_bits(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/convclk_ext_sync.sv
module convclk_ext_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_clk_in,
   output logic ext_rise
);
   logic [SYNC_STAGES:0] stage_q;

   generate
      for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= 1'b0;
               else        stage_q[0] <= ext_clk_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[g] <= 1'b0;
               else        stage_q[g] <= stage_q[g-1];
            end
         end
      end
   endgenerate

   assign ext_rise = stage_q[SYNC_STAGES-1] & ~stage_q[SYNC_STAGES];
endmodule

// File: rtl/convclk_int_div.sv
module convclk_int_div #(
   parameter int INT_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   localparam int DW = convclk_pkg::cnt_bits(INT_DIV - 1);
   localparam logic [DW-1:0] LAST = DW'(INT_DIV - 1);
   localparam bit POW2 = ((INT_DIV & (INT_DIV - 1)) == 0);

   logic [DW-1:0] div_q;
   logic [DW-1:0] div_nxt;

   generate
      if (POW2) begin : g_wrap
         assign div_nxt = div_q + DW'(1);
      end else begin : g_mod
         assign div_nxt = (div_q == LAST) ? '0 : div_q + DW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       div_q <= '0;
      else if (restart) div_q <= '0;
      else if (run)     div_q <= div_nxt;
   end

   assign tick = run & (div_q == LAST);
endmodule

// File: rtl/convclk_step_ctr.sv
module convclk_step_ctr
   import convclk_pkg::*;
#(
   parameter int STEPS = 16,
   localparam int CW = cnt_bits(STEPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_req,
   input  logic          sel_in,
   input  logic          int_tick,
   input  logic          ext_tick,
   output logic          start_acc,
   output logic          busy,
   output logic          step_en,
   output logic          eoc,
   output step_src_e     sel_q,
   output logic [CW-1:0] cnt_q
);
   logic busy_q, eoc_q, last_step;

   assign start_acc = start_req & ~busy_q;
   assign step_en   = busy_q & ((sel_q == SRC_EXTERNAL) ? ext_tick : int_tick);
   assign last_step = step_en & (cnt_q == CW'(STEPS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         sel_q  <= SRC_INTERNAL;
         eoc_q  <= 1'b0;
      end else begin
         eoc_q <= last_step;
         if (start_acc) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            sel_q  <= step_src_e'(sel_in);
         end else if (step_en) begin
            cnt_q <= cnt_q + CW'(1);
            if (last_step) busy_q <= 1'b0;
         end
      end
   end

   assign busy = busy_q;
   assign eoc  = eoc_q;
endmodule

// File: rtl/convclk_mirror.sv
module convclk_mirror #(
   parameter int MIRROR_HI = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_en,
   input  logic cs_n,
   input  logic rd_n,
   output logic clk_mirror
);
   logic gate_ok, mir_q;

   assign gate_ok = ~cs_n & ~rd_n;

   generate
      if (MIRROR_HI == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mir_q <= 1'b0;
            else        mir_q <= step_en & gate_ok;
         end
      end else begin : g_hold
         localparam int HW = convclk_pkg::cnt_bits(MIRROR_HI - 1);
         logic [HW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               left_q <= '0;
               mir_q  <= 1'b0;
            end else begin
               mir_q <= (step_en | (left_q != '0)) & gate_ok;
               if (step_en)            left_q <= HW'(MIRROR_HI - 1);
               else if (left_q != '0)  left_q <= left_q - HW'(1);
            end
         end
      end
   endgenerate

   assign clk_mirror = mir_q;
endmodule

// File: rtl/convclk_selector.sv
module convclk_selector #(
   parameter int STEPS       = 16,
   parameter int INT_DIV     = 4,
   parameter int MIRROR_HI   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic conv_start,
   input  logic src_sel,
   input  logic ext_clk_in,
   input  logic cs_n,
   input  logic rd_n,
   output logic busy,
   output logic step_en,
   output logic eoc,
   output logic clk_mirror
);
   localparam int CNT_W = convclk_pkg::cnt_bits(STEPS);

   generate
      if (STEPS < 2)       begin : g_bad_steps $error("STEPS must be at least 2"); end
      if (INT_DIV < 2)     begin : g_bad_div   $error("INT_DIV must be at least 2"); end
      if (MIRROR_HI < 1 || 2 * MIRROR_HI > INT_DIV)
                           begin : g_bad_hi    $error("MIRROR_HI must lie in 1..INT_DIV/2"); end
      if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   logic                    ext_tick, int_tick, start_acc;
   logic [CNT_W-1:0]        step_cnt;
   convclk_pkg::step_src_e  sel_q;

   convclk_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_clk_in (ext_clk_in),
      .ext_rise   (ext_tick)
   );

   convclk_int_div #(.INT_DIV(INT_DIV)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .restart (start_acc),
      .tick    (int_tick)
   );

   convclk_step_ctr #(.STEPS(STEPS)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (conv_start),
      .sel_in    (src_sel),
      .int_tick  (int_tick),
      .ext_tick  (ext_tick),
      .start_acc (start_acc),
      .busy      (busy),
      .step_en   (step_en),
      .eoc       (eoc),
      .sel_q     (sel_q),
      .cnt_q     (step_cnt)
   );

   convclk_mirror #(.MIRROR_HI(MIRROR_HI)) u_mir (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_en    (step_en),
      .cs_n       (cs_n),
      .rd_n       (rd_n),
      .clk_mirror (clk_mirror)
   );
endmodule

// File: rtl/convclk_checker.sv
module convclk_checker #(
   parameter int STEPS = 16,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             conv_start,
   input logic             cs_n,
   input logic             rd_n,
   input logic             busy,
   input logic             step_en,
   input logic             eoc,
   input logic             clk_mirror,
   input logic             sel_q,
   input logic [CNT_W-1:0] step_cnt
);
   p_step_in_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |-> busy);

   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step_cnt <= CNT_W'(STEPS));

   p_eoc_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |-> (!busy && $past(busy)));

   p_eoc_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |=> !eoc);

   p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && conv_start && step_cnt != '0) |=> (step_cnt != '0));

   p_sel_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sel_q));

   p_mirror_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(step_en && !cs_n && !rd_n) |-> clk_mirror);

   p_mirror_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n || rd_n) |-> !clk_mirror);
endmodule

bind convclk_selector convclk_checker #(.STEPS(STEPS), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .conv_start (conv_start),
   .cs_n       (cs_n),
   .rd_n       (rd_n),
   .busy       (busy),
   .step_en    (step_en),
   .eoc        (eoc),
   .clk_mirror (clk_mirror),
   .sel_q      (sel_q),
   .step_cnt   (step_cnt)
);

// File: tb/tb_convclk_selector.sv
`timescale 1ns/1ps
module tb_convclk_selector;
   localparam int STEPS = 16;
   localparam int INT_DIV = 4;
   localparam int HI = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic conv_start = 1'b0, src_sel = 1'b0, ext_clk_in = 1'b0;
   logic cs_n = 1'b1, rd_n = 1'b1;
   logic busy, step_en, eoc, clk_mirror;

   int n_checks = 0, n_fail = 0;
   int step_seen = 0, mir_seen = 0, eoc_seen = 0;

   always #2 clk = ~clk;

   convclk_selector #(.STEPS(STEPS), .INT_DIV(INT_DIV), .MIRROR_HI(HI), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .src_sel(src_sel),
      .ext_clk_in(ext_clk_in), .cs_n(cs_n), .rd_n(rd_n),
      .busy(busy), .step_en(step_en), .eoc(eoc), .clk_mirror(clk_mirror));

   // behavioural reference model
   int m_busy, m_cnt, m_div, m_sel, m_s1, m_s2, m_s3, m_left, m_mir, m_eoc, m_st;

   function automatic int model_step();
      return (m_busy != 0) && ((m_sel != 0) ? (m_s2 != 0 && m_s3 == 0) : (m_div == INT_DIV - 1));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_cnt = 0; m_div = 0; m_sel = 0;
         m_s1 = 0; m_s2 = 0; m_s3 = 0; m_left = 0; m_mir = 0; m_eoc = 0;
      end else begin
         m_st   = model_step();
         m_eoc  = (m_st != 0 && m_cnt == STEPS - 1);
         m_mir  = (m_st != 0 || m_left != 0) && !cs_n && !rd_n;
         m_left = (m_st != 0) ? HI - 1 : ((m_left != 0) ? m_left - 1 : 0);
         if (m_busy == 0 && conv_start) begin
            m_busy = 1; m_cnt = 0; m_div = 0; m_sel = src_sel;
         end else if (m_busy != 0) begin
            m_div = (m_div == INT_DIV - 1) ? 0 : m_div + 1;
            if (m_st != 0) begin
               m_cnt++;
               if (m_cnt == STEPS) m_busy = 0;
            end
         end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk_in;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check((m_sel != 0) ? "R3" : "R2", "step_en", step_en, model_step());
         check("R4", "busy", busy, m_busy);
         check("R5", "eoc", eoc, m_eoc);
         check("R8", "clk_mirror", clk_mirror, m_mir);
         step_seen += step_en;
         mir_seen  += clk_mirror;
         eoc_seen  += eoc;
      end
   end

   task automatic clear_counts();
      step_seen = 0; mir_seen = 0; eoc_seen = 0;
   endtask

   task automatic pulse_start();
      @(negedge clk) conv_start = 1'b1;
      @(negedge clk) conv_start = 1'b0;
   endtask

   task automatic ext_edges(input int n, input int half);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) ext_clk_in = 1'b1;
         repeat (half - 1) @(negedge clk);
         @(negedge clk) ext_clk_in = 1'b0;
         repeat (half - 1) @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "busy in reset", busy, 0);
      check("R1", "step_en in reset", step_en, 0);
      check("R1", "eoc in reset", eoc, 0);
      check("R1", "clk_mirror in reset", clk_mirror, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "busy after reset", busy, 0);

      // R2 / R8: internal source, outputs enabled
      src_sel = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
      clear_counts();
      pulse_start();
      repeat (80) @(negedge clk);
      check("R2", "internal steps", step_seen, STEPS);
      check("R8", "mirror high cycles", mir_seen, STEPS * HI);
      check("R5", "eoc pulses", eoc_seen, 1);

      // R6 / R7 / R9: start while busy, select flipped, select high
      cs_n = 1'b1;
      clear_counts();
      pulse_start();
      repeat (10) @(negedge clk);
      src_sel = 1'b1;
      pulse_start();
      repeat (75) @(negedge clk);
      check("R6", "steps with start while busy", step_seen, STEPS);
      check("R7", "busy cleared despite select flip", busy, 0);
      check("R9", "mirror with cs_n high", mir_seen, 0);
      check("R6", "eoc pulses", eoc_seen, 1);

      // R3 / R4: external source with surplus edges
      cs_n = 1'b0; src_sel = 1'b1;
      clear_counts();
      pulse_start();
      ext_edges(22, 5);
      repeat (10) @(negedge clk);
      check("R3", "external steps", step_seen, STEPS);
      check("R4", "busy after surplus edges", busy, 0);
      check("R8", "mirror high cycles external", mir_seen, STEPS * HI);

      // R4 / R9: edges while idle
      clear_counts();
      ext_edges(3, 5);
      repeat (10) @(negedge clk);
      check("R4", "steps while idle", step_seen, 0);
      check("R9", "mirror while idle", mir_seen, 0);

      // R8 / R9: read toggled mid-conversion
      src_sel = 1'b0;
      clear_counts();
      pulse_start();
      repeat (20) @(negedge clk);
      rd_n = 1'b1;
      repeat (20) @(negedge clk);
      rd_n = 1'b0;
      repeat (40) @(negedge clk);
      check("R9", "eoc with read toggling", eoc_seen, 1);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule